// File: doc/BRIEF.md
# Independent-Clock Watchdog Timer

This block supervises software by counting toward a timeout that only a refresh can postpone. The count runs either from a slow oscillator that has no relation to the CPU bus clock, or from the bus clock itself. When the count expires, the block drives a system reset and never an interrupt. Because the slow-clock path does not need the bus clock, a bus clock that has stopped still ends in a reset.

Software reaches the block through a small register port. The configuration register holds enable, clock source and timeout length. Only the first write after each reset is accepted, and that write locks the register. Any write to the cause register address restarts the count. Reading the cause register tells a power-on reset apart from a watchdog reset, so a startup self-test can let the watchdog expire on purpose and then confirm that the device really went through reset.

Top module: `indep_wdog`

## Requirements
- R1: After power-on reset the configuration register (address 0) reads 0x07: bit 0 enable = 1, bit 1 source = 1 (slow clock), bit 2 length = 1 (long), and bit 7 lock = 0. The cause register (address 1) reads 0x01: bit 0 is the power-on flag and bit 1 is the watchdog flag.
- R2: With the slow source selected, `sys_rst_o` rises between 2^LOG_SLOW_LONG (long) or 2^LOG_SLOW_SHORT (short) and that count plus 5 slow-clock periods after the refresh write. The defaults are 2^8 and 2^5.
- R3: With the bus source selected, `sys_rst_o` rises exactly 2^LOG_BUS_LONG (long) or 2^LOG_BUS_SHORT (short) bus cycles after the clock edge that takes the refresh write. The defaults are 2^18 and 2^13.
- R4: The first write to the configuration register after a reset loads bits 2:0 and sets lock (bit 7). Every later write is ignored until the next reset.
- R5: A write of any value to the cause register address restarts the count. Reads of any register leave the count alone.
- R6: An expiry drives `sys_rst_o` high for HOLD_CYC periods of the counting clock. The block has no other response to an expiry.
- R7: When enable is 0, no expiry occurs.
- R8: The slow-source expiry drives `sys_rst_o` even while the bus clock is stopped.
- R9: A watchdog reset returns the configuration to 0x07, clears the lock, and makes the cause register read 0x02.
- R10: A power-on reset makes the cause register read 0x01 again, whatever the earlier cause was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| slow_clk | input | 1 | Independent low-frequency oscillator clock |
| por | input | 1 | Power-on reset, active high, synchronous to clk |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write qualifier for bus_sel |
| bus_addr | input | 2 | Register address: 0 configuration, 1 cause/refresh |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| sys_rst_o | output | 1 | System reset to all peripherals and I/O, active high |

## Verification
The clocked checks sample on the bus clock. They assume `por` is held for at least a few slow-clock periods, so that the synchronised copy of the reset reaches the slow domain. They also assume that configuration writes happen only while the bus clock runs. The stimulus keeps `por` high for 30 bus cycles, and it changes register inputs only on falling edges while the bus clock is running. Stopping the bus clock is confined to the one scenario that expects a reset from the slow path alone. That scenario ends with a fresh power-on reset, so no check depends on cause flags that a stopped clock could not record.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADR_CFG   = 2'd0;
    localparam logic [ADDR_W-1:0] ADR_CAUSE = 2'd1;

    // configuration fields, packed so that bit 0 is enable
    typedef struct packed {
        logic long_to;
        logic src_slow;
        logic en;
    } wdog_cfg_t;

    localparam wdog_cfg_t CFG_DEFAULT = '{long_to: 1'b1, src_slow: 1'b1, en: 1'b1};

    // reset cause flags, bit 0 power-on, bit 1 watchdog
    typedef struct packed {
        logic wdog;
        logic pwr;
    } cause_t;

    localparam cause_t CAUSE_POR  = '{wdog: 1'b0, pwr: 1'b1};
    localparam cause_t CAUSE_WDOG = '{wdog: 1'b1, pwr: 1'b0};

    function automatic logic [DATA_W-1:0] view_cfg(wdog_cfg_t c, logic lk);
        logic [DATA_W-1:0] v;
        v = '0;
        v[2:0] = c;
        v[DATA_W-1] = lk;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] view_cause(cause_t s);
        logic [DATA_W-1:0] v;
        v = '0;
        v[1:0] = s;
        return v;
    endfunction

endpackage

// File: rtl/wdog_tmr.sv
module wdog_tmr #(
    parameter int LOG_SHORT = 5,
    parameter int LOG_LONG  = 8,
    parameter int HOLD      = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    input  logic long_sel,
    output logic trip_o
);
    localparam int CW = LOG_LONG;
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LAST_S = CW'((64'd1 << LOG_SHORT) - 64'd1);
    localparam logic [CW-1:0] LAST_L = '1;
    localparam logic [HW-1:0] HOLD_V = HW'(HOLD);

    logic [CW-1:0] cnt_q;
    logic [HW-1:0] hold_q;
    logic [CW-1:0] last;

    assign last = long_sel ? LAST_L : LAST_S;

    // hold phase outranks run so a trip completes even if its own
    // reset effect drops the run condition
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            hold_q <= '0;
        end else if (hold_q != '0) begin
            hold_q <= hold_q - 1'b1;
            cnt_q  <= '0;
        end else if (!run || clr) begin
            cnt_q <= '0;
        end else if (cnt_q == last) begin
            cnt_q  <= '0;
            hold_q <= HOLD_V;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign trip_o = (hold_q != '0);

endmodule

// File: rtl/wdog_slow_dom.sv
module wdog_slow_dom
    import wdog_pkg::*;
#(
    parameter int LOG_SHORT = 5,
    parameter int LOG_LONG  = 8,
    parameter int HOLD      = 4
) (
    input  logic      slow_clk,
    input  logic      por_i,
    input  wdog_cfg_t cfg_i,
    input  logic      tgl_i,
    output logic      trip_o
);
    localparam int SYNC_N = 2;

    logic [SYNC_N-1:0] rst_sync;
    wdog_cfg_t         cfg_s1, cfg_s2;
    logic [2:0]        tgl_s;
    logic              s_rst, s_clr, s_run;

    // reset synchroniser for the slow domain
    always_ff @(posedge slow_clk) begin
        rst_sync <= {rst_sync[SYNC_N-2:0], por_i};
    end
    assign s_rst = rst_sync[SYNC_N-1];

    // quasi-static configuration and the refresh toggle
    always_ff @(posedge slow_clk) begin
        if (s_rst) begin
            cfg_s1 <= CFG_DEFAULT;
            cfg_s2 <= CFG_DEFAULT;
            tgl_s  <= '0;
        end else begin
            cfg_s1 <= cfg_i;
            cfg_s2 <= cfg_s1;
            tgl_s  <= {tgl_s[1:0], tgl_i};
        end
    end

    assign s_clr = tgl_s[2] ^ tgl_s[1];
    assign s_run = cfg_s2.en & cfg_s2.src_slow;

    wdog_tmr #(
        .LOG_SHORT(LOG_SHORT),
        .LOG_LONG (LOG_LONG),
        .HOLD     (HOLD)
    ) u_tmr (
        .clk     (slow_clk),
        .rst     (s_rst),
        .run     (s_run),
        .clr     (s_clr),
        .long_sel(cfg_s2.long_to),
        .trip_o  (trip_o)
    );

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              por_i,
    input  logic              sel_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              bus_trip_i,
    input  logic              slow_trip_i,
    output wdog_cfg_t         cfg_o,
    output logic              lock_o,
    output logic              tgl_o,
    output logic              wr_cause_o,
    output logic              wd_seen_o,
    output cause_t            cause_o
);
    logic [1:0] trip_sync;
    logic       wr_cfg;
    logic       unused_wdata;

    assign unused_wdata = ^wdata_i[DATA_W-1:3];

    assign wr_cfg     = sel_i & we_i & (addr_i == ADR_CFG);
    assign wr_cause_o = sel_i & we_i & (addr_i == ADR_CAUSE);

    always_ff @(posedge clk) begin
        if (por_i) trip_sync <= '0;
        else       trip_sync <= {trip_sync[0], slow_trip_i};
    end

    assign wd_seen_o = bus_trip_i | trip_sync[1];

    // write-once configuration
    always_ff @(posedge clk) begin
        if (por_i || wd_seen_o) begin
            cfg_o  <= CFG_DEFAULT;
            lock_o <= 1'b0;
        end else if (wr_cfg && !lock_o) begin
            cfg_o  <= wdog_cfg_t'(wdata_i[2:0]);
            lock_o <= 1'b1;
        end
    end

    // refresh toggle carried to the slow domain
    always_ff @(posedge clk) begin
        if (por_i)           tgl_o <= 1'b0;
        else if (wr_cause_o) tgl_o <= ~tgl_o;
    end

    // cause of the most recent reset
    always_ff @(posedge clk) begin
        if (por_i)          cause_o <= CAUSE_POR;
        else if (wd_seen_o) cause_o <= CAUSE_WDOG;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADR_CFG)        rdata_o = view_cfg(cfg_o, lock_o);
        else if (addr_i == ADR_CAUSE) rdata_o = view_cause(cause_o);
    end

endmodule

// File: rtl/indep_wdog.sv
module indep_wdog
    import wdog_pkg::*;
#(
    parameter int LOG_SLOW_SHORT = 5,
    parameter int LOG_SLOW_LONG  = 8,
    parameter int LOG_BUS_SHORT  = 13,
    parameter int LOG_BUS_LONG   = 18,
    parameter int HOLD_CYC       = 4
) (
    input  logic              clk,
    input  logic              slow_clk,
    input  logic              por,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_rst_o
);
    wdog_cfg_t cfg_q;
    cause_t    cause_q;
    logic      lock_q, tgl_q, wr_cause, wd_seen;
    logic      bus_trip, slow_trip;

    wdog_regs u_regs (
        .clk        (clk),
        .por_i      (por),
        .sel_i      (bus_sel),
        .we_i       (bus_we),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .rdata_o    (bus_rdata),
        .bus_trip_i (bus_trip),
        .slow_trip_i(slow_trip),
        .cfg_o      (cfg_q),
        .lock_o     (lock_q),
        .tgl_o      (tgl_q),
        .wr_cause_o (wr_cause),
        .wd_seen_o  (wd_seen),
        .cause_o    (cause_q)
    );

    wdog_tmr #(
        .LOG_SHORT(LOG_BUS_SHORT),
        .LOG_LONG (LOG_BUS_LONG),
        .HOLD     (HOLD_CYC)
    ) u_bus_tmr (
        .clk     (clk),
        .rst     (por),
        .run     (cfg_q.en & ~cfg_q.src_slow),
        .clr     (wr_cause),
        .long_sel(cfg_q.long_to),
        .trip_o  (bus_trip)
    );

    wdog_slow_dom #(
        .LOG_SHORT(LOG_SLOW_SHORT),
        .LOG_LONG (LOG_SLOW_LONG),
        .HOLD     (HOLD_CYC)
    ) u_slow (
        .slow_clk(slow_clk),
        .por_i   (por),
        .cfg_i   (cfg_q),
        .tgl_i   (tgl_q),
        .trip_o  (slow_trip)
    );

    assign sys_rst_o = por | bus_trip | slow_trip;

endmodule

// File: rtl/indep_wdog_chk.sv
module indep_wdog_chk
    import wdog_pkg::*;
(
    input logic      clk,
    input logic      por,
    input wdog_cfg_t cfg,
    input logic      lock,
    input logic      wd_seen,
    input cause_t    cause,
    input logic      wr_cause,
    input logic      tgl,
    input logic      bus_trip
);
    // R4
    lock_hold_chk: assert property (@(posedge clk) disable iff (por)
        (lock && !wd_seen) |=> (cfg == $past(cfg)) && lock);

    // R9
    wd_cause_chk: assert property (@(posedge clk) disable iff (por)
        wd_seen |=> (cause == CAUSE_WDOG));

    // R9
    wd_default_chk: assert property (@(posedge clk) disable iff (por)
        wd_seen |=> (cfg == CFG_DEFAULT) && !lock);

    // R5
    refresh_tgl_chk: assert property (@(posedge clk) disable iff (por)
        wr_cause |=> (tgl != $past(tgl)));

    // R7
    bus_run_chk: assert property (@(posedge clk) disable iff (por)
        $rose(bus_trip) |-> $past(cfg.en && !cfg.src_slow));

    // R6
    hold_len_chk: assert property (@(posedge clk) disable iff (por)
        $rose(bus_trip) |=> bus_trip);

endmodule

bind indep_wdog indep_wdog_chk u_chk (
    .clk     (clk),
    .por     (por),
    .cfg     (cfg_q),
    .lock    (lock_q),
    .wd_seen (wd_seen),
    .cause   (cause_q),
    .wr_cause(wr_cause),
    .tgl     (tgl_q),
    .bus_trip(bus_trip)
);

// File: tb/tb_indep_wdog.sv
module tb_indep_wdog;

    localparam int SS = 5, SL = 8, BS = 6, BL = 9, HOLD = 4;
    localparam int BUS_NS = 20, SLOW_NS = 110;

    logic       clk = 1'b0, clk_run = 1'b1, slow_clk = 1'b0;
    logic       por = 1'b1, bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sys_rst_o;

    int nchk = 0, nfail = 0, rises = 0;
    bit done = 0;

    always begin #10; if (clk_run) clk = ~clk; end
    always #55 slow_clk = ~slow_clk;
    always @(posedge sys_rst_o) rises++;

    indep_wdog #(
        .LOG_SLOW_SHORT(SS), .LOG_SLOW_LONG(SL),
        .LOG_BUS_SHORT(BS), .LOG_BUS_LONG(BL), .HOLD_CYC(HOLD)
    ) dut (
        .clk(clk), .slow_clk(slow_clk), .por(por),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_o(sys_rst_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        #2 d = bus_rdata;
        bus_sel = 0;
    endtask

    // call right after wr(): counts edges following the write edge
    task automatic count_to_rst(input int maxc, output int n);
        n = 0;
        while (n < maxc) begin
            @(negedge clk);
            n++;
            if (sys_rst_o) break;
        end
    endtask

    task automatic wait_release();
        while (sys_rst_o) @(negedge clk);
        repeat (30) @(negedge clk);
    endtask

    task automatic do_por();
        @(negedge clk); por = 1;
        repeat (30) @(negedge clk);
        por = 0;
        repeat (5) @(negedge clk);
    endtask

    task automatic chk_slow_window(input string req, input int n, input int lg);
        longint lo, hi, t;
        t  = longint'(n) * BUS_NS;
        lo = longint'(1 << lg) * SLOW_NS;
        hi = longint'((1 << lg) + 5) * SLOW_NS + 2 * BUS_NS;
        chk(t >= lo && t <= hi, req, "slow timeout ns", t, lo);
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        rd(2'd0, d); chk(d == 8'h07, "R1", "cfg after por", d, 8'h07);
        rd(2'd1, d); chk(d == 8'h01, "R1", "cause after por", d, 8'h01);
    endtask

    task automatic t_slow_long();
        int n;
        wr(2'd1, 8'h5a);
        count_to_rst(4000, n);
        chk(sys_rst_o, "R2", "slow long reset seen", sys_rst_o, 1);
        chk_slow_window("R2", n, SL);
        wait_release();
    endtask

    task automatic t_after_wd();
        logic [7:0] d;
        rd(2'd0, d); chk(d == 8'h07, "R9", "cfg after wd reset", d, 8'h07);
        rd(2'd1, d); chk(d == 8'h02, "R9", "cause after wd reset", d, 8'h02);
    endtask

    task automatic t_keepalive();
        int r0 = rises;
        for (int i = 0; i < 5; i++) begin
            wr(2'd1, 8'(i));
            repeat (825) @(negedge clk);
        end
        chk(rises == r0, "R5", "refreshed slow watchdog resets", rises - r0, 0);
    endtask

    task automatic t_lock_bus_short();
        logic [7:0] d;
        int n, w;
        wr(2'd0, 8'h01);
        wr(2'd0, 8'h00);
        rd(2'd0, d); chk(d == 8'h81, "R4", "second cfg write ignored", d, 8'h81);
        wr(2'd1, 8'h00);
        count_to_rst(2000, n);
        chk(n == (1 << BS), "R3", "bus short timeout cycles", n, 1 << BS);
        w = 1;
        forever begin
            @(negedge clk);
            if (!sys_rst_o) break;
            w++;
        end
        chk(w == HOLD, "R6", "bus reset width", w, HOLD);
        wait_release();
        rd(2'd0, d); chk(d == 8'h07, "R9", "unlocked default after bus wd", d, 8'h07);
    endtask

    task automatic t_bus_long_refresh();
        int n;
        wr(2'd0, 8'h05);
        wr(2'd1, 8'h00);
        repeat (300) @(negedge clk);
        chk(!sys_rst_o, "R5", "no reset before refresh", sys_rst_o, 0);
        wr(2'd1, 8'hff);
        count_to_rst(3000, n);
        chk(n == (1 << BL), "R3", "bus long timeout after refresh", n, 1 << BL);
        wait_release();
    endtask

    task automatic t_read_no_refresh();
        int n;
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h00);
        bus_sel = 1; bus_we = 0; bus_addr = 2'd1;
        count_to_rst(2000, n);
        bus_sel = 0;
        chk(n == (1 << BS), "R5", "reads do not refresh", n, 1 << BS);
        wait_release();
    endtask

    task automatic t_slow_short();
        int n;
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h00);
        count_to_rst(2000, n);
        chk(sys_rst_o, "R2", "slow short reset seen", sys_rst_o, 1);
        chk_slow_window("R2", n, SS);
        wait_release();
    endtask

    task automatic t_disabled();
        logic [7:0] d;
        int r0;
        wr(2'd0, 8'h06);
        r0 = rises;
        wr(2'd0, 8'h07);
        repeat (2000) @(negedge clk);
        chk(rises == r0, "R7", "disabled watchdog resets", rises - r0, 0);
        rd(2'd0, d); chk(d == 8'h86, "R4", "locked disabled cfg", d, 8'h86);
    endtask

    task automatic t_new_por();
        logic [7:0] d;
        do_por();
        rd(2'd1, d); chk(d == 8'h01, "R10", "cause after new por", d, 8'h01);
        rd(2'd0, d); chk(d == 8'h07, "R1", "cfg after new por", d, 8'h07);
    endtask

    task automatic t_bus_clock_stopped();
        bit seen = 0;
        wr(2'd1, 8'h00);
        clk_run = 0;
        for (int i = 0; i < 300; i++) begin
            #(SLOW_NS);
            if (sys_rst_o) begin seen = 1; break; end
        end
        chk(seen, "R8", "reset with bus clock stopped", seen, 1);
        clk_run = 1;
        #100;
        do_por();
    endtask

    initial begin
        repeat (30) @(negedge clk);
        por = 0;
        repeat (5) @(negedge clk);
        t_reset_state();
        t_slow_long();
        t_after_wd();
        t_keepalive();
        t_lock_bus_short();
        t_bus_long_refresh();
        t_read_no_refresh();
        t_slow_short();
        t_disabled();
        t_new_por();
        t_bus_clock_stopped();
        finish_run();
    end

    initial begin
        #3_000_000;
        nchk++; nfail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule